// File: doc/BRIEF.md
# DMA Completion Interrupt Control Register

This block is the 32-bit interrupt control and status word of a seven-channel DMA engine. Each channel reports the end of a transfer with a single-cycle completion pulse. The register holds the following fields:

- a per-channel interrupt enable;
- a per-channel sticky completion flag;
- a global interrupt enable;
- a force bit;
- six general-purpose low bits;
- a derived summary flag in the top bit.

Each time the summary flag goes from 0 to 1, the block sends a one-clock request pulse to the system interrupt controller.

Software reads the register and writes it through a simple select, strobe and data port. A write sets the enables, the global enable, the force bit and the low bits directly. The same write acknowledges flags by writing ones, and a zero written to a flag position leaves that flag alone. The summary flag is recomputed from the state that follows each clock edge. Writes cannot change it directly.

Top module: `dma_irq_csr`

## Requirements
- R1: After reset every one of the 32 register bits reads as zero and the request output is low.
- R2: A write (select and strobe both high) stores data bits 0 to 5 and 15 to 23 only. Bits 6 to 14 always read zero. Write data in bits 24 to 31 is never stored as written.
- R3: A completion pulse on channel n sets the flag at bit 24+n on the next edge when the enable at bit 16+n is set. With that enable clear, the pulse leaves the flag unchanged.
- R4: A flag stays set until a write puts a one at its bit position. Writing a zero there leaves it set.
- R5: When a completion and a one-write acknowledge hit the same channel on the same edge, the flag ends up set.
- R6: Bit 31 reads as the force bit (bit 15) OR (the global enable, bit 23, AND any channel having both its enable and its flag set). It reflects the state produced by the same edge.
- R7: The request output is high for exactly one clock, starting at the edge where bit 31 goes from 0 to 1. It is not repeated while bit 31 stays at 1.
- R8: While select is low, read data is zero and a strobe has no effect on the stored state.
- R9: A completion is gated by the enable held before the edge. An enable written on the same edge as the completion does not admit it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, qualified by select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero while not selected |
| ch_done | input | 7 | Per-channel completion pulse, bit n is channel n |
| irq_pulse | output | 1 | One-clock interrupt request |

## Verification
The assertions check several properties on every cycle:

- the reserved bits stay zero;
- only masked fields follow a write;
- flags are sticky and are set only by an enabled completion;
- the force bit implies the summary flag;
- the request pulse lasts one clock and coincides with a rising summary flag.

Some behaviours appear only through the bench's scenarios: a set and an acknowledge colliding on one edge, an enable written on the same edge as a completion, a strobe ignored while not selected, and a repeat pulse suppressed while the summary stays high. Directed and random traffic run alongside a cycle-accurate reference model.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int REG_W     = 32;
   localparam int CH_MAX    = 7;
   localparam int GP_MAX    = 6;
   localparam int FORCE_BIT = 15;
   localparam int EN_LSB    = 16;
   localparam int GEN_BIT   = 23;
   localparam int FL_LSB    = 24;
   localparam int SUM_BIT   = 31;

   function automatic logic [REG_W-1:0] store_mask(input int n_ch, input int gp_w);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < gp_w; i++) m[i] = 1'b1;
      m[FORCE_BIT] = 1'b1;
      for (int i = 0; i < n_ch; i++) m[EN_LSB+i] = 1'b1;
      m[GEN_BIT] = 1'b1;
      return m;
   endfunction

   function automatic logic [REG_W-1:0] ack_mask(input int n_ch);
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < n_ch; i++) m[FL_LSB+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/dma_irq_flag_bank.sv
module dma_irq_flag_bank #(
   parameter int NUM_CH   = 7,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] done,
   input  logic [NUM_CH-1:0] en_q,
   input  logic [NUM_CH-1:0] ack,
   output logic [NUM_CH-1:0] flag_d,
   output logic [NUM_CH-1:0] flag_q
);
   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic set_n;
      assign set_n = done[n] & en_q[n];
      if (SET_WINS) begin : g_set_first
         assign flag_d[n] = set_n | (flag_q[n] & ~ack[n]);
      end else begin : g_ack_first
         assign flag_d[n] = ~ack[n] & (set_n | flag_q[n]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) flag_q[n] <= 1'b0;
         else        flag_q[n] <= flag_d[n];
      end

      AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (SET_WINS && done[n] && en_q[n]) |=> flag_q[n]) else $error("flag not set"); // R3
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[n] && !ack[n]) |=> flag_q[n]) else $error("flag lost"); // R4
      AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_q[n] && !(done[n] && en_q[n])) |=> !flag_q[n]) else $error("flag without cause"); // R3
   end
endmodule

// File: rtl/dma_irq_master.sv
module dma_irq_master #(
   parameter int NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              force_d,
   input  logic              gen_d,
   input  logic [NUM_CH-1:0] en_d,
   input  logic [NUM_CH-1:0] flag_d,
   output logic              sum_q,
   output logic              irq_pulse
);
   logic sum_d;
   assign sum_d = force_d | (gen_d & (|(en_d & flag_d)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q     <= 1'b0;
         irq_pulse <= 1'b0;
      end else begin
         sum_q     <= sum_d;
         irq_pulse <= sum_d & ~sum_q;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |=> !irq_pulse) else $error("pulse too long"); // R7
   AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sum_q) |-> irq_pulse) else $error("missed pulse"); // R7
   AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> sum_q) else $error("pulse without summary"); // R7
endmodule

// File: rtl/dma_irq_csr.sv
module dma_irq_csr
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH   = 7,
   parameter int GP_W     = 6,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic [NUM_CH-1:0] ch_done,
   output logic              irq_pulse
);
   localparam logic [REG_W-1:0] STORE_M = store_mask(NUM_CH, GP_W);
   localparam logic [REG_W-1:0] ACK_M   = ack_mask(NUM_CH);

   if (NUM_CH < 1 || NUM_CH > CH_MAX) begin : g_bad_ch
      $error("NUM_CH must be 1..7");
   end
   if (GP_W < 1 || GP_W > GP_MAX) begin : g_bad_gp
      $error("GP_W must be 1..6");
   end

   logic              wr_ok;
   logic [GP_W-1:0]   gp_q, gp_d;
   logic              force_q, force_d, gen_q, gen_d;
   logic [NUM_CH-1:0] en_q, en_d, ack, flag_d, flag_q;
   logic              sum_q;
   logic              unused_wbits;

   assign wr_ok        = reg_sel & reg_wr;
   assign unused_wbits = ^(reg_wdata & ~(STORE_M | ACK_M));

   assign gp_d    = wr_ok ? reg_wdata[GP_W-1:0]        : gp_q;
   assign force_d = wr_ok ? reg_wdata[FORCE_BIT]       : force_q;
   assign gen_d   = wr_ok ? reg_wdata[GEN_BIT]         : gen_q;
   assign en_d    = wr_ok ? reg_wdata[EN_LSB +: NUM_CH] : en_q;
   assign ack     = wr_ok ? reg_wdata[FL_LSB +: NUM_CH] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gp_q    <= '0;
         force_q <= 1'b0;
         gen_q   <= 1'b0;
         en_q    <= '0;
      end else begin
         gp_q    <= gp_d;
         force_q <= force_d;
         gen_q   <= gen_d;
         en_q    <= en_d;
      end
   end

   dma_irq_flag_bank #(.NUM_CH(NUM_CH), .SET_WINS(SET_WINS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .done   (ch_done),
      .en_q   (en_q),
      .ack    (ack),
      .flag_d (flag_d),
      .flag_q (flag_q)
   );

   dma_irq_master #(.NUM_CH(NUM_CH)) u_master (
      .clk       (clk),
      .rst_n     (rst_n),
      .force_d   (force_d),
      .gen_d     (gen_d),
      .en_d      (en_d),
      .flag_d    (flag_d),
      .sum_q     (sum_q),
      .irq_pulse (irq_pulse)
   );

   always_comb begin
      logic [REG_W-1:0] word;
      word                   = '0;
      word[GP_W-1:0]         = gp_q;
      word[FORCE_BIT]        = force_q;
      word[EN_LSB +: NUM_CH] = en_q;
      word[GEN_BIT]          = gen_q;
      word[FL_LSB +: NUM_CH] = flag_q;
      word[SUM_BIT]          = sum_q;
      reg_rdata              = reg_sel ? word : '0;
   end

   AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[14:6] == '0) else $error("reserved bits set"); // R2
   AST_WRITE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |=> (en_q == $past(reg_wdata[EN_LSB +: NUM_CH])) && (gen_q == $past(reg_wdata[GEN_BIT]))
                && (force_q == $past(reg_wdata[FORCE_BIT]))) else $error("write not stored"); // R2
   AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ok |=> $stable(en_q) && $stable(gen_q) && $stable(force_q) && $stable(gp_q))
      else $error("state changed without write"); // R8
   AST_FORCE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      force_q |-> sum_q) else $error("force ignored"); // R6
   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> reg_rdata == '0) else $error("read data while idle"); // R8
endmodule

// File: tb/dma_irq_csr_tb.sv
module dma_irq_csr_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        sel, wr;
   logic [31:0] wdata;
   logic [6:0]  done;
   logic [31:0] rdata;
   logic        irq;

   always #2 clk = ~clk;

   dma_irq_csr u_dut (
      .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr),
      .reg_wdata(wdata), .reg_rdata(rdata), .ch_done(done), .irq_pulse(irq)
   );

   int          n_chk = 0, n_fail = 0;
   logic [31:0] m_reg = '0;
   logic        m_irq = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic model_edge();
      logic [6:0] a, f;
      logic       old;
      if (!rst_n) begin
         m_reg = '0; m_irq = 1'b0;
      end else begin
         old = m_reg[31];
         a   = (sel && wr) ? wdata[30:24] : 7'd0;
         f   = (m_reg[30:24] & ~a) | (done & m_reg[22:16]);
         if (sel && wr) begin
            m_reg[5:0]   = wdata[5:0];
            m_reg[23:15] = wdata[23:15];
         end
         m_reg[30:24] = f;
         m_reg[31]    = m_reg[15] | (m_reg[23] & (|(m_reg[22:16] & f)));
         m_irq        = m_reg[31] & ~old;
      end
   endtask

   // Drive at a falling edge, update the model at the rising edge, compare at the next falling edge.
   task automatic cyc(input logic s, input logic w, input logic [31:0] d, input logic [6:0] dn);
      sel = s; wr = w; wdata = d; done = dn;
      @(posedge clk);
      model_edge();
      @(negedge clk);
      chk(rdata == (sel ? m_reg : 32'h0), "R6", rdata, sel ? m_reg : 32'h0);
      chk(irq == m_irq, "R7", {31'h0, irq}, {31'h0, m_irq});
   endtask

   task automatic rd();
      cyc(1'b1, 1'b0, 32'h0, 7'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R1 act=%h exp=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; sel = 1'b1; wr = 1'b0; wdata = '0; done = '0;
      @(negedge clk);
      repeat (3) cyc(1'b1, 1'b0, 32'h0, 7'h0);
      chk(rdata == 32'h0, "R1", rdata, 32'h0);
      chk(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      rd();

      // R2: only masked bits stored; force raises summary
      cyc(1'b1, 1'b1, 32'hFFFF_FFFF, 7'h0);
      chk(rdata == 32'h80FF_803F, "R2", rdata, 32'h80FF_803F);
      chk(irq == 1'b1, "R7", {31'h0, irq}, 32'h1);
      rd();
      chk(irq == 1'b0, "R7", {31'h0, irq}, 32'h0);
      cyc(1'b1, 1'b1, 32'h0, 7'h0);
      chk(rdata == 32'h0, "R2", rdata, 32'h0);

      // R3: channel 2 enabled, channel 0 not; global enable off
      cyc(1'b1, 1'b1, 32'h0004_0000, 7'h0);
      cyc(1'b1, 1'b0, 32'h0, 7'b0000101);
      chk(rdata == 32'h0404_0000, "R3", rdata, 32'h0404_0000);
      chk(irq == 1'b0, "R6", {31'h0, irq}, 32'h0);

      // R6: global enable turns the summary on
      cyc(1'b1, 1'b1, 32'h0084_0000, 7'h0);
      chk(rdata == 32'h8484_0000, "R6", rdata, 32'h8484_0000);
      chk(irq == 1'b1, "R7", {31'h0, irq}, 32'h1);

      // R4: writing zero to a flag keeps it; no new pulse
      cyc(1'b1, 1'b1, 32'h0084_0000, 7'h0);
      chk(rdata == 32'h8484_0000, "R4", rdata, 32'h8484_0000);
      chk(irq == 1'b0, "R7", {31'h0, irq}, 32'h0);
      cyc(1'b1, 1'b1, 32'h0484_0000, 7'h0);
      chk(rdata == 32'h0084_0000, "R4", rdata, 32'h0084_0000);

      // R5: completion and acknowledge on the same edge
      cyc(1'b1, 1'b1, 32'h0484_0000, 7'b0000100);
      chk(rdata == 32'h8484_0000, "R5", rdata, 32'h8484_0000);
      chk(irq == 1'b1, "R5", {31'h0, irq}, 32'h1);

      // R9: enable written on the same edge as the completion
      cyc(1'b1, 1'b1, 32'h008C_0000, 7'b0001000);
      chk(rdata[27] == 1'b0, "R9", rdata, 32'h848C_0000);
      cyc(1'b1, 1'b0, 32'h0, 7'b0001000);
      chk(rdata == 32'h8C8C_0000, "R3", rdata, 32'h8C8C_0000);

      // R8: strobe without select
      cyc(1'b0, 1'b1, 32'h7F00_0000, 7'h0);
      chk(rdata == 32'h0, "R8", rdata, 32'h0);
      rd();
      chk(rdata == 32'h8C8C_0000, "R8", rdata, 32'h8C8C_0000);

      // R6: force alone, then re-rise after clearing
      cyc(1'b1, 1'b1, 32'h7F00_8000, 7'h0);
      chk(rdata == 32'h8000_8000, "R6", rdata, 32'h8000_8000);
      cyc(1'b1, 1'b1, 32'h0, 7'h0);
      chk(rdata == 32'h0, "R6", rdata, 32'h0);
      cyc(1'b1, 1'b1, 32'h0000_8000, 7'h0);
      chk(irq == 1'b1, "R7", {31'h0, irq}, 32'h1);
      cyc(1'b1, 1'b1, 32'h0, 7'h0);

      // Random traffic against the reference model
      for (int i = 0; i < 400; i++) begin
         logic [31:0] d;
         d = $urandom;
         if (($urandom % 3) == 0) d[15] = 1'b0;
         cyc(($urandom % 4) != 0, ($urandom % 3) == 0, d, 7'($urandom) & 7'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule